// File: doc/BRIEF.md
# Three-wire serial EEPROM host controller

This block sits on the system side of a three-wire serial EEPROM with 128 words of 16 bits. It drives the chip select, serial clock and data-out wires, and samples the data coming back. Firmware or a sequencer hands it one command at a time: an operation code, a word address, a write word and, for reads, a word count. It then produces the complete serial frame, with the serial clock derived from the system clock.

For reads it ignores the zero the memory places on the line after the last address bit. It shifts in the following 16-bit words, keeps chip select high so that the memory steps through successive addresses, and hands each word back with a one-cycle strobe. For programming commands it lowers chip select to start the memory's internal cycle. After the minimum low time it raises chip select again and polls the status level until the memory reports ready. If the memory never reports ready, a timeout flag is raised. Every command ends with a one-cycle done pulse.

Top module: `mw_eeprom_host`

## Requirements
- R1: After reset, `mw_cs`, `mw_sk`, `busy`, `done`, `rd_valid` and `timeout_err` are all low.
- R2: Each frame is sent MSB first on `mw_di`. It consists of a 1 start bit, a 2-bit line opcode, a 7-bit address field and, for WRITE and WRITE_ALL only, 16 data bits. `cmd_op` is encoded as 0 READ, 1 WRITE, 2 ERASE, 3 ERASE_ALL, 4 WRITE_ALL, 5 ENABLE, 6 and 7 DISABLE. The line opcodes are READ 10, WRITE 01 and ERASE 11. All other commands send opcode 00, and the two top address bits select the command: 11 ENABLE, 00 DISABLE, 10 ERASE_ALL, 01 WRITE_ALL.
- R3: `mw_di` changes only while `mw_sk` is low. Each high phase and each low phase of `mw_sk` lasts at least CLK_DIV system cycles. `mw_sk` is low whenever `mw_cs` is low.
- R4: A READ returns `cmd_count` words, with a count of 0 treated as 1. The words come from consecutive addresses, wrapping from 127 to 0, while `mw_cs` stays high. The bit present after the last address bit is not part of any word. Each word is presented on `rd_data` with a one-cycle `rd_valid` pulse.
- R5: Between any two high periods, `mw_cs` stays low for at least CS_GAP system cycles.
- R6: For WRITE, ERASE, ERASE_ALL and WRITE_ALL, `mw_cs` falls after the last frame bit. After the gap it rises again, and `mw_do` is sampled every cycle. When `mw_do` reads high, `mw_cs` falls and, after a further gap, `done` pulses. The command therefore lasts at least as long as the memory reports busy.
- R7: READ, ENABLE and DISABLE complete without a status poll.
- R8: If `mw_do` stays low for POLL_LIMIT polling cycles, `timeout_err` is set, `mw_cs` is released and the command ends with `done`. `timeout_err` clears when the next command is accepted.
- R9: `busy` is high from the cycle after an accepted `cmd_start` until the cycle in which `done` pulses. `done` lasts one cycle. `cmd_start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Accept a command (in idle only) |
| cmd_op | input | 3 | Operation code, see R2 |
| cmd_addr | input | 7 | Word address |
| cmd_wdata | input | 16 | Word for WRITE and WRITE_ALL |
| cmd_count | input | 8 | Words to read, 0 means 1 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Status poll timed out |
| rd_data | output | 16 | Received word |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data to the memory |
| mw_do | input | 1 | Serial data / ready status from the memory |

## Verification
The bench builds the controller with CLK_DIV=2, CS_GAP=5 and POLL_LIMIT=300. It runs it against a behavioural memory whose programming cycle lasts 80 system cycles. The short clock divider keeps multi-word reads, including the wrap from address 127 to 0, within a few hundred cycles. The small poll limit lets a memory forced permanently busy reach the timeout in one short command, and the 80-cycle busy period is long enough that a missing poll would visibly shorten a programming command.

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host #(
  parameter int CLK_DIV    = 4,
  parameter int CS_GAP     = 8,
  parameter int POLL_LIMIT = 20000,
  parameter int AW         = 7,
  parameter int DW         = 16,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_wdata,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             busy,
  output logic             done,
  output logic             timeout_err,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             mw_cs,
  output logic             mw_sk,
  output logic             mw_di,
  input  logic             mw_do
);

  localparam int TMAX = (CLK_DIV > CS_GAP) ? CLK_DIV : CS_GAP;
  localparam int TW_W = $clog2(TMAX + 1);
  localparam int PL_W = $clog2(POLL_LIMIT + 1);
  localparam int HDR  = 3 + AW;
  localparam int FRM  = HDR + DW;
  localparam int TX_W = $clog2(FRM + 1);
  localparam int RB_W = $clog2(DW);
  localparam logic [TW_W-1:0] DIV_M1 = TW_W'(CLK_DIV - 1);
  localparam logic [TW_W-1:0] GAP_M1 = TW_W'(CS_GAP - 1);
  localparam logic [PL_W-1:0] PL_M1  = PL_W'(POLL_LIMIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_GAP, S_POLL} st_t;

  st_t              st;
  logic [TW_W-1:0]  tmr;
  logic [FRM-1:0]   sh;
  logic [TX_W-1:0]  tx_left;
  logic [RB_W-1:0]  rx_bit;
  logic [DW-1:0]    rx_sh;
  logic [CNT_W-1:0] words_left;
  logic [PL_W-1:0]  poll_cnt;
  logic             rx_on, is_rd, poll_next;

  logic [1:0]       f_op;
  logic [AW-1:0]    f_adr;
  logic             f_dat, f_prog;

  always_comb begin
    f_op   = 2'b00;
    f_adr  = {2'b00, {(AW-2){1'b0}}};
    f_dat  = 1'b0;
    f_prog = 1'b0;
    case (cmd_op)
      3'd0: begin f_op = 2'b10; f_adr = cmd_addr; end
      3'd1: begin f_op = 2'b01; f_adr = cmd_addr; f_dat = 1'b1; f_prog = 1'b1; end
      3'd2: begin f_op = 2'b11; f_adr = cmd_addr; f_prog = 1'b1; end
      3'd3: begin f_adr = {2'b10, {(AW-2){1'b0}}}; f_prog = 1'b1; end
      3'd4: begin f_adr = {2'b01, {(AW-2){1'b0}}}; f_dat = 1'b1; f_prog = 1'b1; end
      3'd5: f_adr = {2'b11, {(AW-2){1'b0}}};
      default: ;
    endcase
  end

  assign busy  = (st != S_IDLE);
  assign mw_di = sh[FRM-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tmr         <= '0;
      sh          <= '0;
      tx_left     <= '0;
      rx_bit      <= '0;
      rx_sh       <= '0;
      words_left  <= '0;
      poll_cnt    <= '0;
      rx_on       <= 1'b0;
      is_rd       <= 1'b0;
      poll_next   <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      mw_cs       <= 1'b0;
      mw_sk       <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_start) begin
          mw_cs       <= 1'b1;
          mw_sk       <= 1'b0;
          sh          <= {1'b1, f_op, f_adr, f_dat ? cmd_wdata : {DW{1'b0}}};
          tx_left     <= f_dat ? TX_W'(FRM) : TX_W'(HDR);
          rx_on       <= 1'b0;
          rx_bit      <= '0;
          is_rd       <= (cmd_op == 3'd0);
          poll_next   <= f_prog;
          words_left  <= (cmd_count == '0) ? CNT_W'(1) : cmd_count;
          timeout_err <= 1'b0;
          tmr         <= DIV_M1;
          st          <= S_LO;
        end
        S_LO: if (tmr != '0) tmr <= tmr - 1'b1;
              else begin mw_sk <= 1'b1; tmr <= DIV_M1; st <= S_HI; end
        S_HI: if (tmr != '0) tmr <= tmr - 1'b1;
        else begin
          mw_sk <= 1'b0;
          tmr   <= DIV_M1;
          st    <= S_LO;
          if (!rx_on) begin
            sh      <= {sh[FRM-2:0], 1'b0};
            tx_left <= tx_left - 1'b1;
            if (tx_left == TX_W'(1)) begin
              if (is_rd) rx_on <= 1'b1;
              else begin mw_cs <= 1'b0; tmr <= GAP_M1; st <= S_GAP; end
            end
          end else begin
            rx_sh <= {rx_sh[DW-2:0], mw_do};
            if (rx_bit == RB_W'(DW - 1)) begin
              rx_bit     <= '0;
              rd_data    <= {rx_sh[DW-2:0], mw_do};
              rd_valid   <= 1'b1;
              words_left <= words_left - 1'b1;
              if (words_left == CNT_W'(1)) begin
                mw_cs <= 1'b0; tmr <= GAP_M1; st <= S_GAP;
              end
            end else rx_bit <= rx_bit + 1'b1;
          end
        end
        S_GAP: if (tmr != '0) tmr <= tmr - 1'b1;
        else if (poll_next) begin
          mw_cs <= 1'b1; poll_next <= 1'b0; poll_cnt <= '0; st <= S_POLL;
        end else begin
          st <= S_IDLE; done <= 1'b1;
        end
        S_POLL: if (mw_do) begin
          mw_cs <= 1'b0; tmr <= GAP_M1; st <= S_GAP;
        end else if (poll_cnt == PL_M1) begin
          timeout_err <= 1'b1; mw_cs <= 1'b0; tmr <= GAP_M1; st <= S_GAP;
        end else poll_cnt <= poll_cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic            sk_prev, cs_prev;
  logic [TW_W-1:0] sk_hold, cs_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_prev <= 1'b0;
      cs_prev <= 1'b0;
      sk_hold <= TW_W'(CLK_DIV);
      cs_hold <= TW_W'(CS_GAP);
    end else begin
      sk_prev <= mw_sk;
      cs_prev <= mw_cs;
      if (mw_sk != sk_prev) sk_hold <= TW_W'(1);
      else if (sk_hold < TW_W'(TMAX)) sk_hold <= sk_hold + 1'b1;
      if (mw_cs != cs_prev) cs_hold <= TW_W'(1);
      else if (cs_hold < TW_W'(TMAX)) cs_hold <= cs_hold + 1'b1;
    end
  end

  // R3
  sk_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sk != sk_prev) |-> (sk_hold >= TW_W'(CLK_DIV)));
  // R3
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mw_cs |-> !mw_sk);
  // R3
  di_steady_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sk && sk_prev) |-> $stable(mw_di));
  // R5
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_cs && !cs_prev) |-> (cs_hold >= TW_W'(CS_GAP)));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  rdv_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
  // R8
  err_from_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(st == S_POLL));

endmodule

// File: tb/tb_mw_eeprom_host.sv
module tb_mw_eeprom_host;
  localparam int DIV = 2, GAP = 5, PLIM = 300, PROG = 80;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0;
  logic [2:0] cmd_op = 0;
  logic [6:0] cmd_addr = 0;
  logic [15:0] cmd_wdata = 0;
  logic [7:0] cmd_count = 0;
  logic busy, done, timeout_err, rd_valid, mw_cs, mw_sk, mw_di, mw_do;
  logic [15:0] rd_data;

  always #5 clk = ~clk;

  mw_eeprom_host #(.CLK_DIV(DIV), .CS_GAP(GAP), .POLL_LIMIT(PLIM)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_count(cmd_count),
    .busy(busy), .done(done), .timeout_err(timeout_err), .rd_data(rd_data),
    .rd_valid(rd_valid), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do));

  // behavioural memory
  logic [15:0] mem [128];
  bit wen, started, rd_mode, stat_mode, stuck, prog_req, m_do;
  int nb, ridx, pbusy;
  logic [1:0] mop;
  logic [6:0] madr;
  logic [15:0] mdat;

  assign mw_do = (stat_mode && !started) ? (pbusy == 0 && !stuck) : m_do;

  always @(posedge mw_sk) if (mw_cs) begin
    if (!started) begin
      if (mw_di) begin started = 1; nb = 0; stat_mode = 0; rd_mode = 0; end
    end else begin
      if (nb < 2) mop = {mop[0], mw_di};
      else if (nb < 9) madr = {madr[5:0], mw_di};
      else if (nb < 25) mdat = {mdat[14:0], mw_di};
      nb++;
      if (nb == 9 && mop == 2'b10) begin rd_mode = 1; ridx = 0; m_do = 0; end
      else if (rd_mode && nb > 9) begin
        m_do = mem[madr][15-ridx];
        ridx++;
        if (ridx == 16) begin ridx = 0; madr++; end
      end
    end
  end

  always @(negedge mw_cs) begin
    if (started && !rd_mode && nb >= 9) begin
      case (mop)
        2'b01: begin stat_mode = 1; if (wen && nb >= 25) begin mem[madr] = mdat; prog_req = 1; end end
        2'b11: begin stat_mode = 1; if (wen) begin mem[madr] = 16'hFFFF; prog_req = 1; end end
        2'b00: case (madr[6:5])
          2'b11: wen = 1;
          2'b00: wen = 0;
          2'b10: begin stat_mode = 1; if (wen) begin for (int i = 0; i < 128; i++) mem[i] = 16'hFFFF; prog_req = 1; end end
          default: begin stat_mode = 1; if (wen && nb >= 25) begin for (int i = 0; i < 128; i++) mem[i] = mdat; prog_req = 1; end end
        endcase
        default: ;
      endcase
    end
    started = 0; rd_mode = 0;
  end

  always @(posedge clk) begin
    if (prog_req) begin pbusy = PROG; prog_req = 0; end
    else if (pbusy > 0) pbusy--;
  end

  // counters and helpers
  int n_run = 0, n_fail = 0, cyc = 0;
  int ngot = 0, last_cycles = 0;
  bit first_busy, last_err;
  logic [15:0] got [8];

  always @(negedge clk) begin
    cyc++;
    if (rd_valid && rst_n) begin if (ngot < 8) got[ngot] = rd_data; ngot++; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  // timing monitors (R3, R5)
  int sk_run = 100, cs_run = 100, v_sk = 0, v_cs = 0, v_di = 0;
  logic sk_d = 0, cs_d = 0, di_d = 0;
  always @(negedge clk) if (rst_n) begin
    if (mw_sk != sk_d) begin if (sk_run < DIV) v_sk++; sk_run = 1; end else sk_run++;
    if (mw_cs && !cs_d && cs_run < GAP) v_cs++;
    if (mw_cs != cs_d) cs_run = 1; else cs_run++;
    if (mw_sk && sk_d && mw_di != di_d) v_di++;
    if (mw_sk && !mw_cs) v_sk++;
    sk_d = mw_sk; cs_d = mw_cs; di_d = mw_di;
  end

  task automatic run_cmd(input logic [2:0] op, input logic [6:0] a, input logic [15:0] d, input logic [7:0] n);
    int w;
    ngot = 0;
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_count = n; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0; first_busy = busy; w = 1;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    last_cycles = w; last_err = timeout_err;
    if (w >= 5000) chk(0, "R9 command never finished", w, 0);
  endtask

  // op(3) addr(7) wdata(16) count(4) exp0(16) exp1(16)
  localparam int NV = 9;
  localparam logic [61:0] VEC [NV] = '{
    {3'd5, 7'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000},
    {3'd1, 7'd3, 16'hA5C3, 4'd0, 16'h0000, 16'h0000},
    {3'd1, 7'd4, 16'h1234, 4'd0, 16'h0000, 16'h0000},
    {3'd0, 7'd3, 16'h0000, 4'd2, 16'hA5C3, 16'h1234},
    {3'd2, 7'd3, 16'h0000, 4'd0, 16'h0000, 16'h0000},
    {3'd0, 7'd3, 16'h0000, 4'd0, 16'hFFFF, 16'h0000},
    {3'd6, 7'd0, 16'h0000, 4'd0, 16'h0000, 16'h0000},
    {3'd1, 7'd4, 16'h0000, 4'd0, 16'h0000, 16'h0000},
    {3'd0, 7'd4, 16'h0000, 4'd1, 16'h1234, 16'h0000}
  };

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mw_cs, mw_sk, busy, done, rd_valid, timeout_err} == 6'b0, "R1 reset outputs",
        {mw_cs, mw_sk, busy, done, rd_valid, timeout_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op; logic [3:0] cnt; int exp_n;
      op = VEC[v][61:59]; cnt = VEC[v][35:32];
      run_cmd(op, VEC[v][58:52], VEC[v][51:36], {4'd0, cnt});
      chk(first_busy, "R9 busy after start", first_busy, 1);
      if (op == 3'd0) begin
        exp_n = (cnt == 0) ? 1 : int'(cnt);
        chk(ngot == exp_n, "R4 word count", ngot, exp_n);
        chk(got[0] == VEC[v][31:16], "R2 R4 first read word", got[0], VEC[v][31:16]);
        if (exp_n > 1) chk(got[1] == VEC[v][15:0], "R4 next address word", got[1], VEC[v][15:0]);
      end else if (op == 3'd1 || op == 3'd2) begin
        if (v != 7) chk(last_cycles > PROG, "R6 poll waits for ready", last_cycles, PROG);
        chk(ngot == 0, "R6 no read strobes", ngot, 0);
      end else begin
        chk(last_cycles < PROG, "R7 no poll for enable/disable", last_cycles, PROG);
      end
    end

    // WRITE_ALL and read across the wrap
    run_cmd(3'd5, 0, 0, 1);
    run_cmd(3'd4, 0, 16'h5AF0, 1);
    chk(last_cycles > PROG, "R6 write-all polled", last_cycles, PROG);
    run_cmd(3'd0, 7'd126, 0, 3);
    chk(ngot == 3 && got[0] == 16'h5AF0 && got[2] == 16'h5AF0, "R2 R4 write-all readback wrap", got[2], 16'h5AF0);
    // ERASE_ALL
    run_cmd(3'd3, 0, 0, 1);
    run_cmd(3'd0, 7'd0, 0, 1);
    chk(got[0] == 16'hFFFF, "R2 erase-all readback", got[0], 16'hFFFF);
    // wrap 127 -> 0
    run_cmd(3'd1, 7'd127, 16'hBEEF, 0);
    run_cmd(3'd1, 7'd0, 16'h0F0F, 0);
    run_cmd(3'd0, 7'd127, 0, 2);
    chk(got[0] == 16'hBEEF && got[1] == 16'h0F0F, "R4 address wrap", {got[0], got[1]}, 32'hBEEF0F0F);

    // start ignored while busy
    begin
      int w;
      ngot = 0;
      @(negedge clk); cmd_op = 3'd0; cmd_addr = 7'd127; cmd_count = 1; cmd_start = 1;
      @(negedge clk); cmd_start = 0;
      repeat (15) @(negedge clk);
      cmd_op = 3'd3; cmd_start = 1;
      @(negedge clk); cmd_start = 0; w = 0;
      while (!done && w < 5000) begin @(negedge clk); w++; end
      repeat (3) @(negedge clk);
      chk(!busy, "R9 start while busy not accepted", busy, 0);
      run_cmd(3'd0, 7'd127, 0, 1);
      chk(got[0] == 16'hBEEF, "R9 memory untouched by ignored start", got[0], 16'hBEEF);
    end

    // timeout
    stuck = 1;
    run_cmd(3'd1, 7'd5, 16'h7777, 0);
    chk(last_err == 1, "R8 timeout flag", last_err, 1);
    chk(last_cycles >= PLIM, "R8 timeout after poll limit", last_cycles, PLIM);
    chk(!mw_cs, "R8 cs released", mw_cs, 0);
    stuck = 0;
    repeat (PROG) @(negedge clk);
    run_cmd(3'd6, 0, 0, 1);
    chk(timeout_err == 0, "R8 flag cleared by next command", timeout_err, 0);

    chk(v_sk == 0 && v_di == 0, "R3 clock phases and data stability", v_sk + v_di, 0);
    chk(v_cs == 0, "R5 chip select gap", v_cs, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule